// File: doc/BRIEF.md
# Accumulator ALU with Flag Policy

This block is the combinational arithmetic and logic stage of an 8-bit accumulator datapath. On each evaluation it takes an operation code, an accumulator operand, a memory operand and the incoming half-carry and carry flags. It returns an 8-bit result and five flag values: half-carry (H), negative (N), zero (Z), overflow (V) and carry (C). Each flag has its own write enable, so the surrounding condition register can tell a computed or forced flag from one that must keep its old value.

Single-operand operations (complement, negate, increment, decrement, clear, test, shifts, rotates and decimal adjust) act on the accumulator port. A memory-form single-operand operation routes its byte to that port. Flags whose enable is low are driven to 0. Operation codes outside the defined set pass the accumulator through and write no flag.

Top module: `acc_alu`

## Requirements
- R1: Add (code 0) gives A+M and add-with-carry (code 1) gives A+M+Cin. Both write all five flags: H is the carry out of bit 3, C the carry out of bit 7, and V is set when two like-signed operands give a result of the other sign.
- R2: Subtract (code 2) gives A−M and subtract-with-carry (code 3) gives A−M−Cin. They write N, Z, V and C, with C being the borrow out of bit 7. They do not write H.
- R3: AND (code 4), OR (code 5) and exclusive OR (code 6) write N and Z and force V to 0. They do not write C or H.
- R4: Ones complement (code 7) gives the bitwise inverse of A, writes N and Z, forces V to 0 and forces C to 1.
- R5: Twos complement (code 8) gives 0−A and writes N and Z. V is 1 only when A is 0x80, and C is 1 exactly when the result is nonzero.
- R6: Increment (code 9) and decrement (code 10) write N, Z and V and never write C. V is 1 for increment of 0x7F and for decrement of 0x80.
- R7: Clear (code 11) gives 0 with N=0, Z=1, V=0, C=0. Test (code 12) gives A, writes N and Z, and forces V and C to 0.
- R8: Shift left (code 13) moves bit 7 into C and fills bit 0 with 0. Arithmetic shift right (code 14) keeps bit 7 and moves bit 0 into C. Logical shift right (code 15) fills bit 7 with 0 and moves bit 0 into C, so N is 0.
- R9: Rotate left (code 16) and rotate right (code 17) form a 9-bit ring through the carry. Cin enters the vacated bit, and the bit shifted out becomes C.
- R10: For codes 13 to 17, N, Z, V and C are all written, and V equals the new N XOR the new C.
- R11: Decimal adjust (code 18) adds 6 to the low digit when Hin is set or the low digit exceeds 9. It adds 0x60 when Cin is set, the high digit exceeds 9, or the high digit is 9 while the low digit exceeds 9. It writes N, Z and C, with C set on Cin or on a high correction, and leaves H and V unwritten.
- R12: H is written only by codes 0 and 1. Every flag output whose enable is low reads 0. Codes 19 to 31 return A unchanged and write no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Operation code |
| acc_in | input | 8 | Accumulator operand; sole operand of single-operand codes |
| mem_in | input | 8 | Memory operand for two-operand codes |
| h_in | input | 1 | Current half-carry flag (used by decimal adjust) |
| c_in | input | 1 | Current carry flag |
| res_out | output | 8 | Operation result |
| h_out | output | 1 | New half-carry value |
| n_out | output | 1 | New negative value |
| z_out | output | 1 | New zero value |
| v_out | output | 1 | New overflow value |
| c_out | output | 1 | New carry value |
| h_we | output | 1 | Half-carry write enable |
| n_we | output | 1 | Negative write enable |
| z_we | output | 1 | Zero write enable |
| v_we | output | 1 | Overflow write enable |
| c_we | output | 1 | Carry write enable |

## Verification
The cases most likely to expose a fault are those where carry and overflow come out of one evaluation together with zero. Adding 0x80 to 0x80 sets C, V and Z at once. A rotate that pushes a set bit into C while its sign changes checks the V = N XOR C rule against both flags at once. For decimal adjust, the low and high digit corrections are made to occur in the same operation (0x9A, and a case with both incoming flags set). Each stimulus is judged by comparing the whole result, enable and flag vector against values worked out by hand.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   typedef enum logic [4:0] {
      OP_ADD = 5'd0,
      OP_ADC = 5'd1,
      OP_SUB = 5'd2,
      OP_SBC = 5'd3,
      OP_AND = 5'd4,
      OP_OR  = 5'd5,
      OP_EOR = 5'd6,
      OP_COM = 5'd7,
      OP_NEG = 5'd8,
      OP_INC = 5'd9,
      OP_DEC = 5'd10,
      OP_CLR = 5'd11,
      OP_TST = 5'd12,
      OP_ASL = 5'd13,
      OP_ASR = 5'd14,
      OP_LSR = 5'd15,
      OP_ROL = 5'd16,
      OP_ROR = 5'd17,
      OP_DAA = 5'd18
   } alu_op_e;

   typedef struct packed {
      logic h;
      logic n;
      logic z;
      logic v;
      logic c;
   } flags_t;

   localparam flags_t FL_NONE = '{h: 1'b0, n: 1'b0, z: 1'b0, v: 1'b0, c: 1'b0};

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
   import acc_alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  alu_op_e          op,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] m,
   input  logic             cin,
   output logic [WIDTH-1:0] res,
   output flags_t           flg,
   output flags_t           we
);
   localparam int MSB = WIDTH - 1;
   localparam logic [WIDTH-1:0] MAX_POS = {1'b0, {(WIDTH-1){1'b1}}};
   localparam logic [WIDTH-1:0] MIN_NEG = {1'b1, {(WIDTH-1){1'b0}}};

   logic [WIDTH:0] wide;
   logic [4:0]     nib;
   logic           ci;

   always_comb begin
      res  = a;
      flg  = FL_NONE;
      we   = FL_NONE;
      wide = '0;
      nib  = '0;
      ci   = 1'b0;
      case (op)
         OP_ADD, OP_ADC: begin
            ci    = (op == OP_ADC) ? cin : 1'b0;
            wide  = {1'b0, a} + {1'b0, m} + {{WIDTH{1'b0}}, ci};
            nib   = {1'b0, a[3:0]} + {1'b0, m[3:0]} + {4'b0000, ci};
            res   = wide[MSB:0];
            flg.h = nib[4];
            flg.c = wide[WIDTH];
            flg.v = (a[MSB] == m[MSB]) && (res[MSB] != a[MSB]);
            we    = '{h: 1'b1, n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b1};
         end
         OP_SUB, OP_SBC: begin
            ci    = (op == OP_SBC) ? cin : 1'b0;
            wide  = {1'b0, a} - {1'b0, m} - {{WIDTH{1'b0}}, ci};
            res   = wide[MSB:0];
            flg.c = wide[WIDTH];
            flg.v = (a[MSB] != m[MSB]) && (res[MSB] != a[MSB]);
            we    = '{h: 1'b0, n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b1};
         end
         OP_NEG: begin
            res   = '0 - a;
            flg.v = (a == MIN_NEG);
            flg.c = (res != '0);
            we    = '{h: 1'b0, n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b1};
         end
         OP_INC: begin
            res   = a + 1'b1;
            flg.v = (a == MAX_POS);
            we    = '{h: 1'b0, n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b0};
         end
         OP_DEC: begin
            res   = a - 1'b1;
            flg.v = (a == MIN_NEG);
            we    = '{h: 1'b0, n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b0};
         end
         OP_CLR: begin
            res = '0;
            we  = '{h: 1'b0, n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b1};
         end
         OP_TST: begin
            res = a;
            we  = '{h: 1'b0, n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b1};
         end
         default: begin
            res = a;
         end
      endcase
      flg.n = res[MSB];
      flg.z = (res == '0);
   end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
   import acc_alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  alu_op_e          op,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] m,
   output logic [WIDTH-1:0] res,
   output flags_t           flg,
   output flags_t           we
);
   always_comb begin
      res = a;
      flg = FL_NONE;
      we  = FL_NONE;
      case (op)
         OP_AND: begin
            res = a & m;
            we  = '{h: 1'b0, n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b0};
         end
         OP_OR: begin
            res = a | m;
            we  = '{h: 1'b0, n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b0};
         end
         OP_EOR: begin
            res = a ^ m;
            we  = '{h: 1'b0, n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b0};
         end
         OP_COM: begin
            res   = ~a;
            flg.c = 1'b1;
            we    = '{h: 1'b0, n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b1};
         end
         default: begin
            res = a;
         end
      endcase
      flg.n = res[WIDTH-1];
      flg.z = (res == '0);
   end
endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift
   import acc_alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  alu_op_e          op,
   input  logic [WIDTH-1:0] a,
   input  logic             cin,
   output logic [WIDTH-1:0] res,
   output flags_t           flg,
   output flags_t           we
);
   localparam int MSB = WIDTH - 1;

   always_comb begin
      res = a;
      flg = FL_NONE;
      we  = FL_NONE;
      case (op)
         OP_ASL: begin
            res   = {a[MSB-1:0], 1'b0};
            flg.c = a[MSB];
         end
         OP_ASR: begin
            res   = {a[MSB], a[MSB:1]};
            flg.c = a[0];
         end
         OP_LSR: begin
            res   = {1'b0, a[MSB:1]};
            flg.c = a[0];
         end
         OP_ROL: begin
            res   = {a[MSB-1:0], cin};
            flg.c = a[MSB];
         end
         OP_ROR: begin
            res   = {cin, a[MSB:1]};
            flg.c = a[0];
         end
         default: begin
            res = a;
         end
      endcase
      flg.n = res[MSB];
      flg.z = (res == '0);
      flg.v = flg.n ^ flg.c;
      if (op inside {OP_ASL, OP_ASR, OP_LSR, OP_ROL, OP_ROR}) begin
         we = '{h: 1'b0, n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b1};
      end
   end
endmodule

// File: rtl/acc_alu_decadj.sv
module acc_alu_decadj
   import acc_alu_pkg::*;
(
   input  logic [7:0] a,
   input  logic       hin,
   input  logic       cin,
   output logic [7:0] res,
   output flags_t     flg,
   output flags_t     we
);
   logic [3:0] lo_dig;
   logic [3:0] hi_dig;
   logic       lo_fix;
   logic       hi_fix;

   always_comb begin
      lo_dig = a[3:0];
      hi_dig = a[7:4];
      lo_fix = hin || (lo_dig > 4'd9);
      hi_fix = cin || (hi_dig > 4'd9) || ((hi_dig == 4'd9) && (lo_dig > 4'd9));
      res    = a + {1'b0, hi_fix, hi_fix, 1'b0, 1'b0, lo_fix, lo_fix, 1'b0};
      flg    = FL_NONE;
      flg.n  = res[7];
      flg.z  = (res == 8'h00);
      flg.c  = hi_fix;
      we     = '{h: 1'b0, n: 1'b1, z: 1'b1, v: 1'b0, c: 1'b1};
   end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int WIDTH   = 8,
   parameter bit HAS_DAA = 1'b1
) (
   input  logic [4:0]       op_sel,
   input  logic [WIDTH-1:0] acc_in,
   input  logic [WIDTH-1:0] mem_in,
   input  logic             h_in,
   input  logic             c_in,
   output logic [WIDTH-1:0] res_out,
   output logic             h_out,
   output logic             n_out,
   output logic             z_out,
   output logic             v_out,
   output logic             c_out,
   output logic             h_we,
   output logic             n_we,
   output logic             z_we,
   output logic             v_we,
   output logic             c_we
);
   if ((WIDTH < 8) || ((WIDTH % 4) != 0)) begin : g_bad_width
      $error("acc_alu: WIDTH must be a multiple of 4 and at least 8");
   end
   if (HAS_DAA && (WIDTH != 8)) begin : g_bad_daa
      $error("acc_alu: decimal adjust needs WIDTH of 8");
   end

   alu_op_e op;
   assign op = alu_op_e'(op_sel);

   logic [WIDTH-1:0] ar_res, lg_res, sh_res, da_res;
   flags_t           ar_flg, lg_flg, sh_flg, da_flg;
   flags_t           ar_we,  lg_we,  sh_we,  da_we;
   logic [WIDTH-1:0] sel_res;
   flags_t           sel_flg, sel_we, fin_flg;

   acc_alu_arith #(.WIDTH(WIDTH)) u_arith (
      .op(op), .a(acc_in), .m(mem_in), .cin(c_in),
      .res(ar_res), .flg(ar_flg), .we(ar_we)
   );

   acc_alu_logic #(.WIDTH(WIDTH)) u_logic (
      .op(op), .a(acc_in), .m(mem_in),
      .res(lg_res), .flg(lg_flg), .we(lg_we)
   );

   acc_alu_shift #(.WIDTH(WIDTH)) u_shift (
      .op(op), .a(acc_in), .cin(c_in),
      .res(sh_res), .flg(sh_flg), .we(sh_we)
   );

   if (HAS_DAA) begin : g_daa
      acc_alu_decadj u_decadj (
         .a(acc_in[7:0]), .hin(h_in), .cin(c_in),
         .res(da_res[7:0]), .flg(da_flg), .we(da_we)
      );
   end else begin : g_no_daa
      assign da_res = acc_in;
      assign da_flg = FL_NONE;
      assign da_we  = FL_NONE;
   end

   always_comb begin
      case (op)
         OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG,
         OP_INC, OP_DEC, OP_CLR, OP_TST: begin
            sel_res = ar_res; sel_flg = ar_flg; sel_we = ar_we;
         end
         OP_AND, OP_OR, OP_EOR, OP_COM: begin
            sel_res = lg_res; sel_flg = lg_flg; sel_we = lg_we;
         end
         OP_ASL, OP_ASR, OP_LSR, OP_ROL, OP_ROR: begin
            sel_res = sh_res; sel_flg = sh_flg; sel_we = sh_we;
         end
         OP_DAA: begin
            sel_res = da_res; sel_flg = da_flg; sel_we = da_we;
         end
         default: begin
            sel_res = acc_in; sel_flg = FL_NONE; sel_we = FL_NONE;
         end
      endcase
      fin_flg = sel_flg & sel_we;
   end

   assign res_out = sel_res;
   assign h_out   = fin_flg.h;
   assign n_out   = fin_flg.n;
   assign z_out   = fin_flg.z;
   assign v_out   = fin_flg.v;
   assign c_out   = fin_flg.c;
   assign h_we    = sel_we.h;
   assign n_we    = sel_we.n;
   assign z_we    = sel_we.z;
   assign v_we    = sel_we.v;
   assign c_we    = sel_we.c;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
   parameter int WIDTH = 8
) (
   input logic [4:0]       op_sel,
   input logic [WIDTH-1:0] acc_in,
   input logic [WIDTH-1:0] res_out,
   input logic             h_out,
   input logic             n_out,
   input logic             z_out,
   input logic             v_out,
   input logic             c_out,
   input logic             h_we,
   input logic             n_we,
   input logic             z_we,
   input logic             v_we,
   input logic             c_we
);
   always_comb begin
      if (!$isunknown({op_sel, acc_in})) begin
         // R12
         h_add_only_chk: assert (!h_we || (op_sel <= 5'd1))
            else $error("half-carry written by code %0d", op_sel);
         // R12
         masked_zero_chk: assert ((h_we || !h_out) && (n_we || !n_out) && (z_we || !z_out)
                                  && (v_we || !v_out) && (c_we || !c_out))
            else $error("flag high with enable low");
         // R12
         undef_pass_chk: assert ((op_sel < 5'd19) ||
                                 ((res_out == acc_in) && !(h_we | n_we | z_we | v_we | c_we)))
            else $error("undefined code changed state");
         // R10
         shift_v_chk: assert (!((op_sel >= 5'd13) && (op_sel <= 5'd17)) || (v_out == (n_out ^ c_out)))
            else $error("shift overflow mismatch");
         // R6
         incdec_c_chk: assert (!((op_sel == 5'd9) || (op_sel == 5'd10)) || !c_we)
            else $error("carry written by inc/dec");
         // R3
         logic_c_chk: assert (!((op_sel >= 5'd4) && (op_sel <= 5'd6)) || (!c_we && v_we && !v_out))
            else $error("logic op flag policy");
         // R7
         zero_flag_chk: assert (!z_we || (z_out == (res_out == '0)))
            else $error("zero flag disagrees with result");
      end
   end
endmodule

bind acc_alu acc_alu_chk #(.WIDTH(WIDTH)) u_chk (
   .op_sel(op_sel), .acc_in(acc_in), .res_out(res_out),
   .h_out(h_out), .n_out(n_out), .z_out(z_out), .v_out(v_out), .c_out(c_out),
   .h_we(h_we), .n_we(n_we), .z_we(z_we), .v_we(v_we), .c_we(c_we)
);

// File: tb/sim_acc_alu.sv
module sim_acc_alu;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [4:0] op_sel = 5'd31;
   logic [7:0] acc_in = 8'h00;
   logic [7:0] mem_in = 8'h00;
   logic       h_in = 1'b0;
   logic       c_in = 1'b0;
   logic [7:0] res_out;
   logic h_out, n_out, z_out, v_out, c_out;
   logic h_we, n_we, z_we, v_we, c_we;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   acc_alu u0 (
      .op_sel(op_sel), .acc_in(acc_in), .mem_in(mem_in), .h_in(h_in), .c_in(c_in),
      .res_out(res_out), .h_out(h_out), .n_out(n_out), .z_out(z_out), .v_out(v_out),
      .c_out(c_out), .h_we(h_we), .n_we(n_we), .z_we(z_we), .v_we(v_we), .c_we(c_we)
   );

   // drive on the falling edge, sample a little later; expected flags ordered h,n,z,v,c
   task automatic run(input string req, input logic [4:0] op, input logic [7:0] a,
                      input logic [7:0] m, input logic hi, input logic ci,
                      input logic [7:0] e_res, input logic [4:0] e_we, input logic [4:0] e_fl);
      @(negedge clk);
      op_sel = op; acc_in = a; mem_in = m; h_in = hi; c_in = ci;
      #2;
      total++;
      if (res_out !== e_res || {h_we, n_we, z_we, v_we, c_we} !== e_we ||
          {h_out, n_out, z_out, v_out, c_out} !== e_fl) begin
         bad++;
         $display("FAIL %s op=%0d a=%h: got res=%h we=%b fl=%b, expected res=%h we=%b fl=%b",
                  req, op, a, res_out, {h_we, n_we, z_we, v_we, c_we},
                  {h_out, n_out, z_out, v_out, c_out}, e_res, e_we, e_fl);
      end
   endtask

   task automatic t_idle;
      // R12: undefined codes pass A and write nothing
      run("R12", 5'd31, 8'h3C, 8'hFF, 1, 1, 8'h3C, 5'b00000, 5'b00000);
      run("R12", 5'd19, 8'hA5, 8'h00, 0, 1, 8'hA5, 5'b00000, 5'b00000);
   endtask

   task automatic t_add;
      run("R1", 5'd0, 8'h3A, 8'h48, 0, 1, 8'h82, 5'b11111, 5'b11010);
      run("R1", 5'd0, 8'h80, 8'h80, 0, 0, 8'h00, 5'b11111, 5'b00111);
      run("R1", 5'd1, 8'hFF, 8'h00, 0, 1, 8'h00, 5'b11111, 5'b10101);
      run("R1", 5'd1, 8'h01, 8'h02, 0, 0, 8'h03, 5'b11111, 5'b00000);
   endtask

   task automatic t_sub;
      run("R2", 5'd2, 8'h10, 8'h20, 1, 0, 8'hF0, 5'b01111, 5'b01001);
      run("R2", 5'd2, 8'h80, 8'h01, 0, 1, 8'h7F, 5'b01111, 5'b00010);
      run("R2", 5'd3, 8'h05, 8'h05, 0, 1, 8'hFF, 5'b01111, 5'b01001);
      run("R2", 5'd3, 8'h05, 8'h05, 0, 0, 8'h00, 5'b01111, 5'b00100);
   endtask

   task automatic t_logic;
      run("R3", 5'd4, 8'hF0, 8'h3C, 0, 1, 8'h30, 5'b01110, 5'b00000);
      run("R3", 5'd5, 8'h80, 8'h01, 0, 1, 8'h81, 5'b01110, 5'b01000);
      run("R3", 5'd6, 8'h55, 8'h55, 0, 1, 8'h00, 5'b01110, 5'b00100);
      run("R4", 5'd7, 8'h00, 8'h00, 0, 0, 8'hFF, 5'b01111, 5'b01001);
      run("R4", 5'd7, 8'hFF, 8'h00, 0, 0, 8'h00, 5'b01111, 5'b00101);
   endtask

   task automatic t_neg;
      run("R5", 5'd8, 8'h80, 8'h00, 0, 0, 8'h80, 5'b01111, 5'b01011);
      run("R5", 5'd8, 8'h00, 8'h00, 0, 1, 8'h00, 5'b01111, 5'b00100);
      run("R5", 5'd8, 8'h01, 8'h00, 0, 0, 8'hFF, 5'b01111, 5'b01001);
   endtask

   task automatic t_incdec;
      run("R6", 5'd9,  8'h7F, 8'h00, 0, 1, 8'h80, 5'b01110, 5'b01010);
      run("R6", 5'd9,  8'hFF, 8'h00, 0, 0, 8'h00, 5'b01110, 5'b00100);
      run("R6", 5'd10, 8'h80, 8'h00, 0, 1, 8'h7F, 5'b01110, 5'b00010);
      run("R6", 5'd10, 8'h01, 8'h00, 0, 0, 8'h00, 5'b01110, 5'b00100);
   endtask

   task automatic t_clr_tst;
      run("R7", 5'd11, 8'h5A, 8'hFF, 1, 1, 8'h00, 5'b01111, 5'b00100);
      run("R7", 5'd12, 8'h80, 8'h00, 1, 1, 8'h80, 5'b01111, 5'b01000);
      run("R7", 5'd12, 8'h00, 8'h00, 0, 1, 8'h00, 5'b01111, 5'b00100);
   endtask

   task automatic t_shift;
      run("R8 R10", 5'd13, 8'hC1, 8'h00, 0, 0, 8'h82, 5'b01111, 5'b01001);
      run("R8 R10", 5'd13, 8'h40, 8'h00, 0, 1, 8'h80, 5'b01111, 5'b01010);
      run("R8 R10", 5'd14, 8'h81, 8'h00, 0, 0, 8'hC0, 5'b01111, 5'b01001);
      run("R8 R10", 5'd15, 8'h01, 8'h00, 0, 0, 8'h00, 5'b01111, 5'b00111);
      run("R8", 5'd15, 8'hFE, 8'h00, 0, 1, 8'h7F, 5'b01111, 5'b00000);
   endtask

   task automatic t_rotate;
      run("R9 R10", 5'd16, 8'h80, 8'h00, 0, 1, 8'h01, 5'b01111, 5'b00011);
      run("R9 R10", 5'd17, 8'h01, 8'h00, 0, 1, 8'h80, 5'b01111, 5'b01001);
      run("R9", 5'd17, 8'h02, 8'h00, 0, 0, 8'h01, 5'b01111, 5'b00000);
   endtask

   task automatic t_daa;
      run("R11", 5'd18, 8'h0B, 8'h00, 0, 0, 8'h11, 5'b01101, 5'b00000);
      run("R11", 5'd18, 8'h9A, 8'h00, 0, 0, 8'h00, 5'b01101, 5'b00101);
      run("R11", 5'd18, 8'h12, 8'h00, 1, 1, 8'h78, 5'b01101, 5'b00001);
      run("R11", 5'd18, 8'h45, 8'h00, 0, 0, 8'h45, 5'b01101, 5'b00000);
      run("R11", 5'd18, 8'hA0, 8'h00, 0, 0, 8'h00, 5'b01101, 5'b00101);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      t_idle();
      t_add();
      t_sub();
      t_logic();
      t_neg();
      t_incdec();
      t_clr_tst();
      t_shift();
      t_rotate();
      t_daa();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule